// File: doc/BRIEF.md
# Periodic Clock Slew Corrector

This block advances a wide local time register by a small correction once per adjustment interval, so that the time register is pulled toward the disciplined value. It holds a signed pending-phase value and a signed frequency-skew value. An upstream update engine writes both through a load port. On every interval tick, a fixed right shift of the pending phase is moved out of that register and into the time register, together with a fixed right shift of the skew. The pending phase therefore shrinks geometrically, while the skew term keeps adding the same amount on every tick. No multiplier or divider is used.

The time register only moves forward. A negative summed correction is forced to zero, and an addition that would pass the top of the register stops at all-ones. A small counter records how many ticks in a row have gone by without any forward correction. Step adjustments, loop-filter arithmetic and the generation of the tick are handled elsewhere.

Top module: `slew_corrector`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, adjOut, clockOut and watchdogOut are zero, and the internal skew value is zero.
- R2: A cycle with loadValid high and tick low places loadAdj on adjOut and stores loadSkew as the skew from the next cycle on. It leaves clockOut and watchdogOut unchanged.
- R3: A cycle with tick high and loadValid low sets adjOut to adjOut minus (adjOut arithmetically shifted right by PHASE_SH), where adjOut is the value before the edge.
- R4: On that same edge, clockOut grows by the correction. The correction is the sum of (adjOut >>> PHASE_SH) and (skew >>> FREQ_SH), both taken before the edge and both treated as two's-complement signed values.
- R5: A negative summed correction is replaced by zero, so clockOut never decreases.
- R6: If clockOut plus the correction exceeds 2^CLK_W-1, clockOut becomes all-ones instead of wrapping.
- R7: When loadValid and tick are high in the same cycle, the load of R2 takes place and no correction is made. clockOut is unchanged, and the tick still counts for the watchdog.
- R8: On a tick without a load whose correction (after R5) is nonzero, watchdogOut becomes 0. On any other tick it grows by one and saturates at 2^WD_W-1. Without a tick it holds its value.
- R9: A cycle with both tick and loadValid low leaves adjOut, clockOut, watchdogOut and the skew unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Adjustment-interval strobe |
| loadValid | input | 1 | Load new phase and skew values |
| loadAdj | input | ADJ_W | Signed pending-phase value to load |
| loadSkew | input | SKEW_W | Signed skew value to load |
| adjOut | output | ADJ_W | Current signed pending-phase value |
| clockOut | output | CLK_W | Local time register |
| watchdogOut | output | WD_W | Ticks since the last nonzero correction, saturating |

## Verification
Several properties are checked on every cycle. The time register never moves backward. A load always wins over a tick. Idle cycles keep all state. The pending-phase magnitude never grows on a tick. The watchdog never leaves its saturated value except by clearing to zero. The exact size of each correction can only be shown by the bench's scenarios. These include floor rounding of negative shifts, the zero clamp when phase and skew are opposed, the ceiling stop of the time register, and the watchdog clearing only after a nonzero correction. To show them, the bench sweeps every phase value of a small configuration against several skew values.

// File: rtl/slew_pkg.sv
package slew_pkg;
  typedef struct packed {
    logic loadEn;   // take new phase and skew values
    logic stepEn;   // perform one interval correction
    logic wdClear;  // a nonzero correction was applied
    logic wdBump;   // tick without a nonzero correction
  } slewStrobe_t;
endpackage

// File: rtl/slew_ctrl.sv
module slew_ctrl #(
  parameter int WD_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tick,
  input  logic                     loadValid,
  input  logic                     corrNonZero,
  output slew_pkg::slewStrobe_t    stb,
  output logic [WD_W-1:0]          watchdog
);
  localparam logic [WD_W-1:0] WD_MAX = {WD_W{1'b1}};

  logic [WD_W-1:0] wdQ;

  always_comb begin
    stb.loadEn  = loadValid;
    stb.stepEn  = tick && !loadValid;
    stb.wdClear = tick && !loadValid && corrNonZero;
    stb.wdBump  = tick && !(tick && !loadValid && corrNonZero);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdQ <= '0;
    end else if (stb.wdClear) begin
      wdQ <= '0;
    end else if (stb.wdBump && (wdQ != WD_MAX)) begin
      wdQ <= wdQ + 1'b1;
    end
  end

  assign watchdog = wdQ;
endmodule

// File: rtl/slew_datapath.sv
module slew_datapath #(
  parameter int ADJ_W    = 16,
  parameter int SKEW_W   = 16,
  parameter int CLK_W    = 32,
  parameter int PHASE_SH = 2,
  parameter int FREQ_SH  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  slew_pkg::slewStrobe_t stb,
  input  logic [ADJ_W-1:0]      loadAdj,
  input  logic [SKEW_W-1:0]     loadSkew,
  output logic [ADJ_W-1:0]      adj,
  output logic [CLK_W-1:0]      clockVal,
  output logic                  corrNonZero
);
  localparam int SUM_W = ((ADJ_W > SKEW_W) ? ADJ_W : SKEW_W) + 1;
  localparam int PAD_W = CLK_W + 1 - SUM_W;

  logic signed [ADJ_W-1:0]  adjQ;
  logic signed [ADJ_W-1:0]  phaseTerm;
  logic signed [SKEW_W-1:0] skewQ;
  logic signed [SKEW_W-1:0] freqTerm;
  logic signed [SUM_W-1:0]  corrSum;
  logic [SUM_W-1:0]         corrPos;
  logic [CLK_W-1:0]         clockQ;
  logic [CLK_W:0]           clockSum;
  logic [CLK_W-1:0]         clockNext;

  // Fixed shifts replace all scaling.
  assign phaseTerm = adjQ >>> PHASE_SH;
  assign freqTerm  = skewQ >>> FREQ_SH;

  assign corrSum = $signed({{(SUM_W-ADJ_W){phaseTerm[ADJ_W-1]}}, phaseTerm})
                 + $signed({{(SUM_W-SKEW_W){freqTerm[SKEW_W-1]}}, freqTerm});

  // Monotonic time: a backward correction becomes zero.
  assign corrPos     = corrSum[SUM_W-1] ? '0 : corrSum;
  assign corrNonZero = |corrPos;

  assign clockSum  = {1'b0, clockQ} + {{PAD_W{1'b0}}, corrPos};
  assign clockNext = clockSum[CLK_W] ? {CLK_W{1'b1}} : clockSum[CLK_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adjQ   <= '0;
      skewQ  <= '0;
      clockQ <= '0;
    end else if (stb.loadEn) begin
      adjQ  <= loadAdj;
      skewQ <= loadSkew;
    end else if (stb.stepEn) begin
      adjQ   <= adjQ - phaseTerm;
      clockQ <= clockNext;
    end
  end

  assign adj      = adjQ;
  assign clockVal = clockQ;
endmodule

// File: rtl/slew_corrector.sv
module slew_corrector #(
  parameter int ADJ_W    = 16,
  parameter int SKEW_W   = 16,
  parameter int CLK_W    = 32,
  parameter int WD_W     = 4,
  parameter int PHASE_SH = 2,
  parameter int FREQ_SH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              loadValid,
  input  logic [ADJ_W-1:0]  loadAdj,
  input  logic [SKEW_W-1:0] loadSkew,
  output logic [ADJ_W-1:0]  adjOut,
  output logic [CLK_W-1:0]  clockOut,
  output logic [WD_W-1:0]   watchdogOut
);
  slew_pkg::slewStrobe_t stb;
  logic                  corrNonZero;

  slew_ctrl #(.WD_W(WD_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .loadValid   (loadValid),
    .corrNonZero (corrNonZero),
    .stb         (stb),
    .watchdog    (watchdogOut)
  );

  slew_datapath #(
    .ADJ_W(ADJ_W), .SKEW_W(SKEW_W), .CLK_W(CLK_W),
    .PHASE_SH(PHASE_SH), .FREQ_SH(FREQ_SH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .loadAdj     (loadAdj),
    .loadSkew    (loadSkew),
    .adj         (adjOut),
    .clockVal    (clockOut),
    .corrNonZero (corrNonZero)
  );
endmodule

// File: rtl/slew_corrector_checker.sv
module slew_corrector_checker #(
  parameter int ADJ_W  = 16,
  parameter int SKEW_W = 16,
  parameter int CLK_W  = 32,
  parameter int WD_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              loadValid,
  input logic [ADJ_W-1:0]  loadAdj,
  input logic [SKEW_W-1:0] loadSkew,
  input logic [ADJ_W-1:0]  adjOut,
  input logic [CLK_W-1:0]  clockOut,
  input logic [WD_W-1:0]   watchdogOut
);
  localparam logic [WD_W-1:0] WD_TOP = {WD_W{1'b1}};

  function automatic logic [ADJ_W:0] magOf(input logic [ADJ_W-1:0] v);
    logic [ADJ_W:0] ext;
    ext = {v[ADJ_W-1], v};
    return v[ADJ_W-1] ? (~ext + 1'b1) : ext;
  endfunction

  // R5: the time register never goes backward
  assert_clock_monotonic_R5: assert property (@(posedge clk) disable iff (!rstN)
    clockOut >= $past(clockOut));

  // R2 / R7: a load always takes the new phase value
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> adjOut == $past(loadAdj));

  // R7: a load cycle never moves the time register
  assert_load_holds_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> $stable(clockOut));

  // R9: idle cycles keep all visible state
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !loadValid) |=> ($stable(adjOut) && $stable(clockOut) && $stable(watchdogOut)));

  // R3: the pending phase magnitude never grows on a correction
  assert_phase_decays_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !loadValid) |=> magOf(adjOut) <= magOf($past(adjOut)));

  // R8: a saturated watchdog either stays or clears
  assert_wd_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (tick && watchdogOut == WD_TOP) |=> (watchdogOut == WD_TOP || watchdogOut == '0));
endmodule

bind slew_corrector slew_corrector_checker #(
  .ADJ_W(ADJ_W), .SKEW_W(SKEW_W), .CLK_W(CLK_W), .WD_W(WD_W)
) u_checker (
  .clk(clk), .rstN(rstN), .tick(tick), .loadValid(loadValid),
  .loadAdj(loadAdj), .loadSkew(loadSkew), .adjOut(adjOut),
  .clockOut(clockOut), .watchdogOut(watchdogOut)
);

// File: tb/slew_corrector_bench.sv
`timescale 1ns/1ps
module slew_corrector_bench;
  localparam int ADJ_W = 8, SKEW_W = 8, CLK_W = 16, WD_W = 3;
  localparam int PHASE_SH = 2, FREQ_SH = 3;
  localparam int CLK_MAX = 65535, WD_MAX = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0;
  logic loadValid = 1'b0;
  logic [ADJ_W-1:0]  loadAdj = '0;
  logic [SKEW_W-1:0] loadSkew = '0;
  logic [ADJ_W-1:0]  adjOut;
  logic [CLK_W-1:0]  clockOut;
  logic [WD_W-1:0]   watchdogOut;

  int checks = 0, fails = 0;
  int mx = 0, my = 0, mclk = 0, mwd = 0;

  always #2.5 clk = ~clk;

  slew_corrector #(
    .ADJ_W(ADJ_W), .SKEW_W(SKEW_W), .CLK_W(CLK_W), .WD_W(WD_W),
    .PHASE_SH(PHASE_SH), .FREQ_SH(FREQ_SH)
  ) u_slew_corrector (
    .clk(clk), .rstN(rstN), .tick(tick), .loadValid(loadValid),
    .loadAdj(loadAdj), .loadSkew(loadSkew), .adjOut(adjOut),
    .clockOut(clockOut), .watchdogOut(watchdogOut)
  );

  function automatic int floorDiv(input int a, input int d);
    return (a >= 0) ? a / d : -((-a + d - 1) / d);
  endfunction

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string rAdj, input string rClk, input string rWd);
    checkVal(rAdj, "adjOut", int'($signed(adjOut)), mx);
    checkVal(rClk, "clockOut", int'(clockOut), mclk);
    checkVal(rWd, "watchdogOut", int'(watchdogOut), mwd);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; loadValid = 1'b0;
    repeat (3) @(negedge clk);
    mx = 0; my = 0; mclk = 0; mwd = 0;
    checkAll("R1", "R1", "R1");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1", "R1", "R1");
  endtask

  // One cycle of stimulus, then compare against the arithmetic model.
  task automatic step(input bit doLoad, input int xv, input int yv, input bit doTick);
    string rAdj, rClk, rWd;
    int ph, fr, c, raw;
    @(negedge clk);
    loadValid = doLoad; tick = doTick;
    loadAdj = xv[ADJ_W-1:0]; loadSkew = yv[SKEW_W-1:0];
    if (doLoad) begin
      mx = xv; my = yv;
      rAdj = doTick ? "R7" : "R2"; rClk = rAdj; rWd = doTick ? "R7" : "R2";
      if (doTick && mwd < WD_MAX) mwd++;
    end else if (doTick) begin
      ph = floorDiv(mx, 1 << PHASE_SH);
      fr = floorDiv(my, 1 << FREQ_SH);
      raw = ph + fr;
      c = (raw < 0) ? 0 : raw;
      rClk = (raw < 0) ? "R5" : ((mclk + c > CLK_MAX) ? "R6" : "R4");
      mclk = (mclk + c > CLK_MAX) ? CLK_MAX : mclk + c;
      mx = mx - ph;
      if (c > 0) mwd = 0; else if (mwd < WD_MAX) mwd++;
      rAdj = "R3"; rWd = "R8";
    end else begin
      rAdj = "R9"; rClk = "R9"; rWd = "R9";
    end
    @(posedge clk); #1;
    loadValid = 1'b0; tick = 1'b0;
    checkAll(rAdj, rClk, rWd);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : timeoutGuard
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL timeout: actual running expected finished");
    finishRun();
  end

  initial begin
    int ys[4];
    ys[0] = -128; ys[1] = -9; ys[2] = 0; ys[3] = 77;
    doReset();
    // R9: idle cycles hold reset state
    step(0, 0, 0, 0);
    step(0, 0, 0, 0);
    // R8: ticks with zero correction push the watchdog to saturation
    for (int i = 0; i < 10; i++) step(0, 0, 0, 1);
    // Sweep every phase value against several skews (R2..R8)
    for (int x = -128; x < 128; x++) begin
      for (int k = 0; k < 4; k++) begin
        if (((x + k) & 7) == 0) step(1, x, ys[k], 1);   // R7 collision
        else step(1, x, ys[k], 0);                      // R2 plain load
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        if (k == 0) step(0, 0, 0, 0);                   // R9 idle
      end
    end
    // R6: drive the time register into its ceiling
    doReset();
    step(1, 127, 127, 0);
    for (int i = 0; i < 4600; i++) step(0, 0, 0, 1);
    checkVal("R6", "clockOut at ceiling", int'(clockOut), CLK_MAX);
    finishRun();
  end
endmodule